// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Engine

This block is the device-side half of extended message-signalled interrupts. It holds a small table of interrupt vectors in a 4 KB register page. Each vector owns a 16-byte slot that stores a 64-bit target address, a 32-bit payload and a control word whose bit 0 masks the vector. The second half of the page exposes a read-only pending summary. A host reaches the page through a simple dword port. Device logic raises interrupts by vector number and gets back either a memory-write message, carried on a valid/ready output, or a pending record that is sent later.

Delivery is gated twice. A per-vector use counter must be nonzero, so vectors that software has not configured stay silent. The vector must also be unmasked, both by the function-wide mask input and by its own control bit. A masked request sets a pending bit. As soon as that vector becomes unmasked, whether by a table write or by the function mask dropping, the pending request is drained as a message. At reset the page is cleared and every implemented vector starts masked.

Top module: `msix_engine`

## Requirements
- R1: After reset every table word reads 0 except each implemented vector's control word, which reads 1. The pending dword reads 0, all use counters are 0, and msg_valid is low.
- R2: Vector v (v < NVEC) occupies byte offsets 16v..16v+15: address low at +0, address high at +4, payload at +8, control at +12 with the mask in bit 0. Full-dword writes store the value and reads return it.
- R3: Only host_be == 4'b1111 is serviced. A narrower write changes nothing. A narrower read returns host_rdata = 0 with host_rerr = 1. Address bits [1:0] are ignored.
- R4: The dword at offset 0x800 reads the pending bits, with bit v belonging to vector v, and writes to it have no effect. Any offset outside the table and this dword reads 0.
- R5: A request whose vector is not below NVEC, or whose use counter is 0, is consumed and dropped: no message and no pending bit.
- R6: A request for a used vector that is masked (func_mask = 1 or control bit 0 = 1) sets its pending bit and emits no message.
- R7: A request for a used, unmasked vector emits one message with msg_addr = {high, low} and msg_data = payload of that entry.
- R8: A pending vector that becomes unmasked, either through a control write or through func_mask falling, is sent as one message and its pending bit clears. Several drain in ascending vector order.
- R9: While msg_valid is high and msg_ready low, msg_valid, msg_addr and msg_data hold.
- R10: A drain has priority over a new request. req_ready is low while a message is waiting or any pending vector is unmasked.
- R11: use_up = 1 increments the counter of use_vec, saturating at 2^CNT_W-1. use_up = 0 decrements it only when it is nonzero. A decrement that reaches 0 clears that vector's pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; runs the reset sequence |
| func_mask | input | 1 | Function-wide mask |
| host_valid | input | 1 | Host access strobe |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Byte offset within the page |
| host_be | input | 4 | Byte enables; only 4'b1111 is serviced |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, combinational |
| host_rerr | output | 1 | Narrow read rejected |
| req_valid | input | 1 | Interrupt request |
| req_vec | input | 5 | Requested vector |
| req_ready | output | 1 | Request accepted this cycle |
| use_valid | input | 1 | Use-counter update strobe |
| use_up | input | 1 | 1 = mark used, 0 = mark unused |
| use_vec | input | 5 | Vector whose counter is updated |
| msg_valid | output | 1 | Message available |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |
| msg_ready | input | 1 | Message taken |

## Verification
A drain and a fresh request can compete for the single output slot in the same cycle. The bench provokes this by holding msg_ready low with a message already waiting. It then unmasks a pending vector by a table write and raises a request for another vector. When msg_ready rises, the message log must show the waiting message, then the drained vector, then the new request, each exactly once. The pending dword must read 0 afterwards. A second sweep masks the whole function, queues every vector and releases them together, checking the ascending drain order.

// File: rtl/msix_engine.sv
module msix_engine #(
  parameter int NVEC  = 8,
  parameter int CNT_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        func_mask,
  input  logic        host_valid,
  input  logic        host_write,
  input  logic [11:0] host_addr,
  input  logic [3:0]  host_be,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_rerr,
  input  logic        req_valid,
  input  logic [4:0]  req_vec,
  output logic        req_ready,
  input  logic        use_valid,
  input  logic        use_up,
  input  logic [4:0]  use_vec,
  output logic        msg_valid,
  output logic [63:0] msg_addr,
  output logic [31:0] msg_data,
  input  logic        msg_ready
);
  localparam int MAXV = 32;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [9:0] PEND_DW = 10'h200;

  logic [31:0]      tbl [MAXV][4];
  logic [CNT_W-1:0] cnt [MAXV];
  logic [31:0]      pend;
  logic             dr_any;
  logic [4:0]       dr_vec;

  wire full_dw  = host_be == 4'b1111;
  wire tbl_hit  = int'(host_addr[11:4]) < NVEC;
  wire [4:0] hv = host_addr[8:4];
  wire req_in   = int'(req_vec) < NVEC;
  wire use_in   = int'(use_vec) < NVEC;
  wire req_mask = func_mask | tbl[req_vec][3][0];
  wire req_take = req_valid && req_ready && req_in && cnt[req_vec] != '0;

  always_comb begin
    dr_any = 1'b0;
    dr_vec = '0;
    for (int v = NVEC - 1; v >= 0; v--)
      if (pend[v] && !func_mask && !tbl[v][3][0]) begin
        dr_any = 1'b1;
        dr_vec = 5'(v);
      end
  end

  assign req_ready = !msg_valid && !dr_any;
  assign host_rerr = host_valid && !host_write && !full_dw;

  always_comb begin
    host_rdata = '0;
    if (host_valid && !host_write && full_dw) begin
      if (tbl_hit) host_rdata = tbl[hv][host_addr[3:2]];
      else if (host_addr[11:2] == PEND_DW) host_rdata = pend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < MAXV; v++) begin
        for (int w = 0; w < 4; w++)
          tbl[v][w] <= (w == 3 && v < NVEC) ? 32'd1 : 32'd0;
        cnt[v] <= '0;
      end
      pend      <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      if (msg_valid && msg_ready) msg_valid <= 1'b0;
      if (!msg_valid) begin
        if (dr_any) begin
          msg_valid    <= 1'b1;
          msg_addr     <= {tbl[dr_vec][1], tbl[dr_vec][0]};
          msg_data     <= tbl[dr_vec][2];
          pend[dr_vec] <= 1'b0;
        end else if (req_take) begin
          if (req_mask) pend[req_vec] <= 1'b1;
          else begin
            msg_valid <= 1'b1;
            msg_addr  <= {tbl[req_vec][1], tbl[req_vec][0]};
            msg_data  <= tbl[req_vec][2];
          end
        end
      end
      if (host_valid && host_write && full_dw && tbl_hit)
        tbl[hv][host_addr[3:2]] <= host_wdata;
      if (use_valid && use_in) begin
        if (use_up) begin
          if (cnt[use_vec] != CNT_MAX) cnt[use_vec] <= cnt[use_vec] + 1'b1;
        end else if (cnt[use_vec] != '0) begin
          cnt[use_vec] <= cnt[use_vec] - 1'b1;
          if (cnt[use_vec] == 1) pend[use_vec] <= 1'b0;
        end
      end
    end
  end

  assert_msg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  assert_drain_issues_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid && dr_any |=> msg_valid);

  assert_drain_blocks_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dr_any |-> !req_ready);

  always_comb
    if (rst_n && host_valid && !host_write && !full_dw)
      assert_narrow_read_R3: assert (host_rdata == 32'd0);

  for (genvar g = 0; g < NVEC; g++) begin : g_chk
    assert_unused_not_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] == '0 |-> !pend[g]);
  end
endmodule

// File: tb/tb_msix_engine.sv
`timescale 1ns/1ps
module tb_msix_engine;
  localparam int NV = 8;
  logic clk = 0, rst_n = 0, func_mask = 0;
  logic host_valid = 0, host_write = 0;
  logic [11:0] host_addr = 0;
  logic [3:0] host_be = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic host_rerr;
  logic req_valid = 0, req_ready;
  logic [4:0] req_vec = 0;
  logic use_valid = 0, use_up = 0;
  logic [4:0] use_vec = 0;
  logic msg_valid, msg_ready = 1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] lg_addr[$];
  logic [31:0] lg_data[$];

  msix_engine #(.NVEC(NV), .CNT_W(4)) dut (.*);

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    #1;
    if (msg_valid && msg_ready) begin
      lg_addr.push_back(msg_addr);
      lg_data.push_back(msg_data);
    end
  end

  function automatic logic [63:0] ea(int v);
    return {32'hA0 + 32'(v), 32'h1000_0000 + 32'(v) * 16};
  endfunction
  function automatic logic [31:0] ed(int v);
    return 32'hD000_0000 | 32'(v);
  endfunction

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic hw(logic [11:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    host_valid = 1; host_write = 1; host_addr = a; host_wdata = d; host_be = be;
    @(negedge clk);
    host_valid = 0; host_write = 0;
  endtask

  task automatic hr(logic [11:0] a, output logic [31:0] d, output logic e,
                    input logic [3:0] be = 4'hF);
    @(negedge clk);
    host_valid = 1; host_write = 0; host_addr = a; host_be = be;
    #1; d = host_rdata; e = host_rerr;
    host_valid = 0;
  endtask

  task automatic req(int v);
    @(negedge clk);
    req_valid = 1; req_vec = 5'(v);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic use_op(int v, logic up);
    @(negedge clk);
    use_valid = 1; use_up = up; use_vec = 5'(v);
    @(negedge clk);
    use_valid = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic clr_log();
    lg_addr.delete(); lg_data.delete();
  endtask

  task automatic expect_log(string r, int n, int vs[]);
    chk(r, 64'(lg_addr.size()), 64'(n));
    for (int i = 0; i < n && i < lg_addr.size(); i++) begin
      chk(r, lg_addr[i], ea(vs[i]));
      chk(r, 64'(lg_data[i]), 64'(ed(vs[i])));
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int v = 0; v < NV; v++)
      for (int w = 0; w < 4; w++) begin
        hr(12'(v * 16 + w * 4), d, e);
        chk("R1", 64'(d), (w == 3) ? 64'd1 : 64'd0);
      end
    hr(12'h800, d, e); chk("R1 pend", 64'(d), 0);
    chk("R1 msg", 64'(msg_valid), 0);
    // R2 program and read back
    for (int v = 0; v < NV; v++) begin
      hw(12'(v * 16), ea(v)[31:0]);
      hw(12'(v * 16 + 4), ea(v)[63:32]);
      hw(12'(v * 16 + 8), ed(v));
      hw(12'(v * 16 + 12), 32'd0);
    end
    for (int v = 0; v < NV; v++) begin
      hr(12'(v * 16), d, e); chk("R2 lo", 64'(d), 64'(ea(v)[31:0]));
      hr(12'(v * 16 + 4), d, e); chk("R2 hi", 64'(d), 64'(ea(v)[63:32]));
      hr(12'(v * 16 + 8), d, e); chk("R2 data", 64'(d), 64'(ed(v)));
    end
    // R3 narrow access and low address bits
    hw(12'h028, 32'hFFFF_FFFF, 4'h3);
    hr(12'h028, d, e); chk("R3 narrow wr", 64'(d), 64'(ed(2)));
    hr(12'h028, d, e, 4'h1); chk("R3 narrow rd", 64'(d), 0); chk("R3 rerr", 64'(e), 1);
    hw(12'h02B, 32'h1234_5678);
    hr(12'h028, d, e); chk("R3 low bits", 64'(d), 64'h1234_5678);
    hw(12'h028, ed(2));
    // R4 other offsets
    hr(12'h400, d, e); chk("R4 hole", 64'(d), 0);
    hr(12'h804, d, e); chk("R4 hole2", 64'(d), 0);
    // R5 unused and out of range
    clr_log();
    req(3); req(12); req(31); settle();
    expect_log("R5", 0, '{0});
    hr(12'h800, d, e); chk("R5 pend", 64'(d), 0);
    // R7 delivery for all vectors
    for (int v = 0; v < NV; v++) use_op(v, 1);
    clr_log();
    for (int v = NV - 1; v >= 0; v--) begin
      req(v); settle();
      chk("R7 count", 64'(lg_addr.size()), 64'(NV - v));
      if (lg_addr.size() > 0) begin
        chk("R7 addr", lg_addr[$], ea(v));
        chk("R7 data", 64'(lg_data[$]), 64'(ed(v)));
      end
    end
    // R6 per-entry mask, R8 drain on control write
    clr_log();
    hw(12'h03C, 32'd1);
    req(3); settle();
    expect_log("R6", 0, '{0});
    hr(12'h800, d, e); chk("R6 pend", 64'(d), 64'h8);
    hw(12'h800, 32'h0);
    hr(12'h800, d, e); chk("R4 ro", 64'(d), 64'h8);
    hw(12'h03C, 32'd0); settle();
    expect_log("R8 entry", 1, '{3});
    hr(12'h800, d, e); chk("R8 clr", 64'(d), 0);
    // R6 function mask, R8 ordered drain
    clr_log();
    func_mask = 1;
    for (int v = NV - 1; v >= 0; v--) req(v);
    settle();
    expect_log("R6 func", 0, '{0});
    hr(12'h800, d, e); chk("R6 func pend", 64'(d), 64'hFF);
    @(negedge clk); func_mask = 0;
    repeat (30) @(negedge clk);
    expect_log("R8 order", NV, '{0, 1, 2, 3, 4, 5, 6, 7});
    hr(12'h800, d, e); chk("R8 all clr", 64'(d), 0);
    // R9 backpressure, R10 drain before request
    clr_log();
    hw(12'h03C, 32'd1);
    req(3);
    @(negedge clk); msg_ready = 0;
    req(1);
    repeat (3) @(negedge clk);
    chk("R9 hold", 64'(msg_valid), 1);
    chk("R9 addr", msg_addr, ea(1));
    hw(12'h03C, 32'd0);
    @(negedge clk);
    req_valid = 1; req_vec = 5;
    repeat (2) @(negedge clk);
    chk("R10 ready", 64'(req_ready), 0);
    msg_ready = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
    settle();
    expect_log("R10 order", 3, '{1, 3, 5});
    hr(12'h800, d, e); chk("R10 pend", 64'(d), 0);
    // R11 decrement to zero clears pending
    clr_log();
    hw(12'h04C, 32'd1);
    req(4);
    hr(12'h800, d, e); chk("R11 set", 64'(d), 64'h10);
    use_op(4, 0);
    hr(12'h800, d, e); chk("R11 clr", 64'(d), 0);
    hw(12'h04C, 32'd0); settle();
    req(4); settle();
    expect_log("R11 unused", 0, '{0});
    // R11 saturation: 17 more increments, 14 decrements leaves 1
    for (int i = 0; i < 17; i++) use_op(6, 1);
    for (int i = 0; i < 14; i++) use_op(6, 0);
    req(6); settle();
    expect_log("R11 sat", 1, '{6});
    use_op(6, 0);
    use_op(6, 0);
    req(6); settle();
    expect_log("R11 zero", 1, '{6});
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule